// File: doc/BRIEF.md
# Two-Wire Multi-Channel Setpoint Target

This block is a two-wire serial target (I2C, 7-bit addressing) that keeps eight 10-bit channel setpoints and drives them in parallel to downstream logic. Each setpoint has its own one-cycle update strobe. The serial lines are oversampled on the system clock. Two flops bring each line into the clock domain, and an optional three-sample majority vote then removes single-sample spikes. The open-drain data line is modelled as a pull-down request: when `sda_pull` is high, the pad must drive the line low.

A static mode pin selects the frame layout. In bulk mode one transfer writes, or reads back, all eight channels as sixteen bytes in channel order. In indexed mode the first byte after the address is a register byte that picks one channel, and two data bytes follow. A read of one channel uses a repeated START. Every 10-bit value travels as a byte pair: the first byte holds the two top bits in its bits 1:0, and the second byte holds the lower eight bits.

The strobe `ch_upd[i]` acts as a valid with no ready. The serial bus cannot be stalled, so the consumer must take the new value in the cycle of the pulse. There is no back-pressure path.

Top module: `vref_i2c_target`

## Requirements
- R1: The target answers only the 7-bit address {6'b111010, addr_sel}, which is 0x74 or 0x75. For any other address it leaves SDA released in the acknowledge slot and ignores the rest of the transfer.
- R2: The target pulls SDA low in the acknowledge clock after a matching address byte and after every byte written to it.
- R3: Bulk mode (bulk_mode=1) write: data bytes 2k and 2k+1 (counting from 0) form the pair for channel k, with k=0..7. In the first byte, bits 1:0 are value bits 9:8 and bits 7:2 are ignored. The second byte is value bits 7:0.
- R4: A channel changes, and its strobe pulses for exactly one cycle, only when the second byte of its pair is acknowledged. A STOP or START after only the first byte of a pair leaves the old value in place. At most one strobe is high in any cycle.
- R5: Bulk mode read: the target returns the sixteen bytes in the write order, MSB first. The six top bits of each first byte read as 0. The read ends at the master's NACK.
- R6: Indexed mode (bulk_mode=0) write: the first data byte is a register byte whose bits 3:0 select the channel and whose bits 7:4 are ignored. A byte pair in the R3 format follows it.
- R7: Indexed read: the master writes the register byte, sends a repeated START with the read address, and then receives the selected channel's pair.
- R8: Register indexes 8 to 15 are acknowledged but change no channel, and reads of them return 0x00 bytes.
- R9: In bulk mode, data bytes after the sixteenth are acknowledged and ignored, and bulk reads past the sixteenth byte return 0x00.
- R10: With filt_en=1, a low spike of one sample on SDA while SCL is high has no effect on the transfer. With filt_en=0 the same spike is seen as START followed by STOP, and it aborts the transfer.
- R11: After reset all setpoints are 0, no strobe is high, and sda_pull is low.
- R12: A STOP returns the target to idle with SDA released. While not addressed, the target changes no setpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | High requests that the pad drive SDA low |
| addr_sel | input | 1 | Address bit 0 (static) |
| bulk_mode | input | 1 | 1 selects bulk frames, 0 selects indexed frames (static) |
| filt_en | input | 1 | 1 enables the majority spike filter on both lines |
| ch_vals | output | 80 | Setpoints; channel k is bits [10k+9:10k] |
| ch_upd | output | 8 | One-cycle update strobe per channel |

## Verification
The critical overlap is between the data-bit capture and the START/STOP detector. Both act while SCL is high, so an SDA edge inside the high phase is claimed by both. The bench injects a one-sample low pulse on a '1' data bit of the second byte of a pair, in the middle of the SCL high phase. It runs this once with the filter on and once with it off. With the filter on, the channel must take the new value. With the filter off, the pulse must read as START plus STOP, so the channel keeps its old value.

// File: rtl/vref_i2c_pkg.sv
package vref_i2c_pkg;
  localparam int NUM_CH_D = 8;
  localparam int VAL_W_D  = 10;
  localparam logic [5:0] ADDR_HI_D = 6'b111010;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_WR,
    PH_RD
  } phase_t;
endpackage

// File: rtl/vref_i2c_deglitch.sv
module vref_i2c_deglitch (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic en,
  output logic dout
);
  logic s1, s2, h1, h2, maj;

  assign maj = (s2 & h1) | (s2 & h2) | (h1 & h2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; h1 <= 1'b0; h2 <= 1'b0; dout <= 1'b0;
    end else begin
      s1   <= din;
      s2   <= s1;
      h1   <= s2;
      h2   <= h1;
      dout <= en ? maj : s2;
    end
  end

  // With the vote active, a change at the output needs the newest sample to agree.
  p_spike_vote_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && $past(en, 2) && (dout != $past(dout))) |-> ($past(s2) == dout));
endmodule

// File: rtl/vref_i2c_bank.sv
module vref_i2c_bank #(
  parameter int NUM_CH = 8,
  parameter int VAL_W  = 10,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [VAL_W-1:0]        wr_data,
  output logic [NUM_CH*VAL_W-1:0] vals,
  output logic [NUM_CH-1:0]       upd
);
  logic [VAL_W-1:0] val_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q[g] <= '0;
        upd[g]   <= 1'b0;
      end else begin
        upd[g] <= hit;
        if (hit) val_q[g] <= wr_data;
      end
    end

    assign vals[g*VAL_W +: VAL_W] = val_q[g];

    p_change_has_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(val_q[g]) |-> upd[g]);
  end

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(upd));
endmodule

// File: rtl/vref_i2c_engine.sv
module vref_i2c_engine
  import vref_i2c_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int VAL_W  = 10,
  parameter logic [5:0] ADDR_HI = 6'b111010,
  localparam int IDX_W = $clog2(NUM_CH),
  localparam int HI_W  = VAL_W - 8,
  localparam int CNT_W = $clog2(2*NUM_CH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl,
  input  logic                    sda,
  input  logic                    addr_lsb,
  input  logic                    bulk_mode,
  input  logic [NUM_CH*VAL_W-1:0] vals,
  output logic                    sda_oe,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [VAL_W-1:0]        wr_data
);
  localparam logic [CNT_W-1:0] BULK_N  = CNT_W'(2*NUM_CH);
  localparam logic [3:0]       PTR_LIM = 4'(NUM_CH);

  phase_t           phase;
  logic             scl_q, sda_q, start_c, stop_c, rise, fall;
  logic [3:0]       bitcnt, ptr;
  logic             in_ack, got_reg, mnack;
  logic [7:0]       shreg, rd_byte;
  logic [6:0]       tx7;
  logic [CNT_W-1:0] bidx;
  logic [HI_W-1:0]  hi;
  logic [VAL_W-1:0] varr [NUM_CH];
  logic [VAL_W-1:0] sel_v;
  logic [IDX_W-1:0] sel_ch;
  logic             sel_ok;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign varr[g] = vals[g*VAL_W +: VAL_W];
  end

  assign start_c = scl & scl_q & sda_q & ~sda;
  assign stop_c  = scl & scl_q & ~sda_q & sda;
  assign rise    = scl & ~scl_q;
  assign fall    = ~scl & scl_q;

  always_comb begin
    if (bulk_mode) begin
      sel_ok = bidx < BULK_N;
      sel_ch = bidx[IDX_W:1];
    end else begin
      sel_ok = (ptr < PTR_LIM) && (bidx < CNT_W'(2));
      sel_ch = ptr[IDX_W-1:0];
    end
    sel_v = varr[sel_ch];
    if (!sel_ok)      rd_byte = '0;
    else if (bidx[0]) rd_byte = sel_v[7:0];
    else              rd_byte = {{(16-VAL_W){1'b0}}, sel_v[VAL_W-1:8]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b0; sda_q <= 1'b0;
    end else begin
      scl_q <= scl; sda_q <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; bitcnt <= '0; in_ack <= 1'b0; shreg <= '0; tx7 <= '0;
      bidx <= '0; ptr <= '0; got_reg <= 1'b0; hi <= '0; mnack <= 1'b0;
      sda_oe <= 1'b0; wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        phase <= PH_ADDR; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
        bidx <= '0; got_reg <= 1'b0;
      end else if (stop_c) begin
        phase <= PH_IDLE; in_ack <= 1'b0; sda_oe <= 1'b0;
      end else begin
        unique case (phase)
          PH_ADDR, PH_WR: begin
            if (rise && !in_ack) begin
              shreg  <= {shreg[6:0], sda};
              bitcnt <= bitcnt + 4'd1;
            end else if (fall && !in_ack && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (phase == PH_ADDR) begin
                if (shreg[7:1] == {ADDR_HI, addr_lsb}) begin
                  in_ack <= 1'b1; sda_oe <= 1'b1;
                  phase  <= shreg[0] ? PH_RD : PH_WR;
                end else begin
                  phase <= PH_IDLE;
                end
              end else begin
                in_ack <= 1'b1; sda_oe <= 1'b1;
                if (bulk_mode) begin
                  if (bidx < BULK_N) begin
                    if (!bidx[0]) hi <= shreg[HI_W-1:0];
                    else begin
                      wr_en <= 1'b1; wr_idx <= bidx[IDX_W:1]; wr_data <= {hi, shreg};
                    end
                    bidx <= bidx + 1'b1;
                  end
                end else if (!got_reg) begin
                  ptr <= shreg[3:0]; got_reg <= 1'b1;
                end else begin
                  if (bidx == '0) hi <= shreg[HI_W-1:0];
                  else if (bidx == CNT_W'(1) && ptr < PTR_LIM) begin
                    wr_en <= 1'b1; wr_idx <= ptr[IDX_W-1:0]; wr_data <= {hi, shreg};
                  end
                  if (bidx < CNT_W'(2)) bidx <= bidx + 1'b1;
                end
              end
            end else if (fall && in_ack) begin
              in_ack <= 1'b0; sda_oe <= 1'b0;
            end
          end
          PH_RD: begin
            if (in_ack) begin
              if (rise) mnack <= sda;
              else if (fall) begin
                in_ack <= 1'b0;
                if (mnack) begin
                  phase <= PH_IDLE; sda_oe <= 1'b0;
                end else begin
                  tx7 <= rd_byte[6:0]; sda_oe <= ~rd_byte[7]; bitcnt <= '0;
                end
              end
            end else if (rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0; in_ack <= 1'b1; bitcnt <= '0;
                if (bidx != BULK_N) bidx <= bidx + 1'b1;
              end else begin
                tx7 <= {tx7[5:0], 1'b0}; sda_oe <= ~tx7[6];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_idle_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe);
  p_start_releases_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> !sda_oe);
  p_write_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(phase) == PH_WR));
  p_foreign_no_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_c && !stop_c && phase == PH_ADDR && fall && !in_ack && bitcnt == 4'd8 &&
     shreg[7:1] != {ADDR_HI, addr_lsb}) |=> !sda_oe);
endmodule

// File: rtl/vref_i2c_target.sv
module vref_i2c_target
  import vref_i2c_pkg::*;
#(
  parameter int NUM_CH = NUM_CH_D,
  parameter int VAL_W  = VAL_W_D,
  parameter logic [5:0] ADDR_HI = ADDR_HI_D,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_in,
  input  logic                    sda_in,
  output logic                    sda_pull,
  input  logic                    addr_sel,
  input  logic                    bulk_mode,
  input  logic                    filt_en,
  output logic [NUM_CH*VAL_W-1:0] ch_vals,
  output logic [NUM_CH-1:0]       ch_upd
);
  logic [1:0]       raw, clean;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [VAL_W-1:0] wr_data;

  assign raw = {sda_in, scl_in};

  for (genvar l = 0; l < 2; l++) begin : g_line
    vref_i2c_deglitch u_flt (
      .clk(clk), .rst_n(rst_n), .din(raw[l]), .en(filt_en), .dout(clean[l])
    );
  end

  vref_i2c_engine #(.NUM_CH(NUM_CH), .VAL_W(VAL_W), .ADDR_HI(ADDR_HI)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl(clean[0]), .sda(clean[1]),
    .addr_lsb(addr_sel), .bulk_mode(bulk_mode), .vals(ch_vals),
    .sda_oe(sda_pull), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  vref_i2c_bank #(.NUM_CH(NUM_CH), .VAL_W(VAL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .vals(ch_vals), .upd(ch_upd)
  );
endmodule

// File: tb/test_vref_i2c_target.sv
`timescale 1ns/1ps
module test_vref_i2c_target;
  localparam int Q = 8;
  // register byte, first data byte, second data byte
  localparam logic [23:0] VEC [6] = '{
    24'h02FD5A, 24'hF703FF, 24'h300200, 24'h0B0333, 24'h05FC1F, 24'h810180
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0, bulk_mode = 1'b0, filt_en = 1'b0;
  logic sda_pull;
  logic [79:0] ch_vals;
  logic [7:0]  ch_upd;
  logic sda_bus;
  int nchk = 0, nerr = 0;
  int updc [8];
  logic [9:0] expv [8];
  bit done = 1'b0;

  assign sda_bus = sda_m & ~sda_pull;
  always #2.5 clk = ~clk;

  vref_i2c_target i_vref_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_pull(sda_pull),
    .addr_sel(addr_sel), .bulk_mode(bulk_mode), .filt_en(filt_en),
    .ch_vals(ch_vals), .ch_upd(ch_upd)
  );

  initial for (int c = 0; c < 8; c++) updc[c] = 0;
  always @(negedge clk) for (int c = 0; c < 8; c++) if (ch_upd[c]) updc[c]++;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int c = 0; c < 8; c++) chk(req, int'(ch_vals[c*10 +: 10]), int'(expv[c]));
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gl, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q/2);
      if (i == gl) begin sda_m = 1'b0; tick(1); sda_m = 1'b1; tick(Q/2 - 1); end
      else tick(Q/2);
      tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); ack = !sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = nack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  task automatic idx_write(input logic [6:0] a, input logic [7:0] r, input logic [7:0] h,
                           input logic [7:0] l, input int gl, output int acks);
    bit ak;
    acks = 0;
    bus_start();
    send_byte({a, 1'b0}, -1, ak); acks += int'(ak);
    send_byte(r, -1, ak); acks += int'(ak);
    send_byte(h, -1, ak); acks += int'(ak);
    send_byte(l, gl, ak); acks += int'(ak);
    bus_stop();
  endtask

  task automatic idx_read(input logic [7:0] r, output logic [7:0] h, output logic [7:0] l);
    bit ak;
    bus_start();
    send_byte(8'hE8, -1, ak);
    send_byte(r, -1, ak);
    bus_start();
    send_byte(8'hE9, -1, ak);
    recv_byte(1'b0, h);
    recv_byte(1'b1, l);
    bus_stop();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int acks, u0 [8];
    bit ak;
    logic [7:0] h, l;
    logic [9:0] bv;
    for (int c = 0; c < 8; c++) expv[c] = '0;
    tick(5); rst_n = 1'b1; tick(4);

    // R11: reset state
    chk_all("R11 setpoint after reset");
    chk("R11 strobes after reset", int'(ch_upd), 0);
    chk("R11 sda_pull after reset", int'(sda_pull), 0);

    // R1/R12: foreign address 0x76 gets no ACK and its data is ignored
    bus_start();
    send_byte(8'hEC, -1, ak); chk("R1 foreign address ack", int'(ak), 0);
    send_byte(8'h03, -1, ak); chk("R12 unaddressed data ack", int'(ak), 0);
    bus_stop();
    chk("R12 sda released after stop", int'(sda_pull), 0);
    chk_all("R12 no change while unaddressed");

    // R6/R7/R8/R2: vector table, indexed write then indexed read back
    for (int k = 0; k < 6; k++) begin
      logic [3:0] ch;
      ch = VEC[k][19:16];
      for (int c = 0; c < 8; c++) u0[c] = updc[c];
      idx_write(7'h74, VEC[k][23:16], VEC[k][15:8], VEC[k][7:0], -1, acks);
      chk("R2 acks on indexed write", acks, 4);
      if (ch < 4'd8) expv[ch[2:0]] = {VEC[k][9:8], VEC[k][7:0]};
      chk_all("R6/R8 setpoints after indexed write");
      for (int c = 0; c < 8; c++)
        chk("R4 strobe count", updc[c] - u0[c], (ch < 4'd8 && ch[2:0] == 3'(c)) ? 1 : 0);
      idx_read(VEC[k][23:16], h, l);
      chk("R7/R8 indexed read first byte", int'(h), ch < 4'd8 ? int'(expv[ch[2:0]][9:8]) : 0);
      chk("R7/R8 indexed read second byte", int'(l), ch < 4'd8 ? int'(expv[ch[2:0]][7:0]) : 0);
    end

    // R1: address bit 0 from addr_sel
    addr_sel = 1'b1;
    idx_write(7'h74, 8'h03, 8'h02, 8'hA5, -1, acks);
    chk("R1 0x74 rejected when addr_sel=1", acks, 0);
    chk_all("R1 no write through rejected address");
    idx_write(7'h75, 8'h03, 8'h02, 8'hA5, -1, acks);
    expv[3] = 10'h2A5;
    chk("R1 0x75 accepted", acks, 4);
    chk_all("R1 write through 0x75");
    addr_sel = 1'b0;

    // R3/R9: bulk write of 16 bytes plus 2 extra
    bulk_mode = 1'b1;
    for (int c = 0; c < 8; c++) u0[c] = updc[c];
    bus_start();
    send_byte(8'hE8, -1, ak); chk("R2 bulk address ack", int'(ak), 1);
    for (int c = 0; c < 8; c++) begin
      bv = 10'((c * 181 + 37) % 1024);
      send_byte({6'b101010, bv[9:8]}, -1, ak); chk("R3 bulk first byte ack", int'(ak), 1);
      send_byte(bv[7:0], -1, ak); chk("R3 bulk second byte ack", int'(ak), 1);
      expv[c] = bv;
    end
    send_byte(8'hFF, -1, ak); chk("R9 extra byte ack", int'(ak), 1);
    send_byte(8'hFF, -1, ak); chk("R9 extra byte ack", int'(ak), 1);
    bus_stop();
    chk_all("R3/R9 setpoints after bulk write");
    for (int c = 0; c < 8; c++) chk("R4 one strobe per channel", updc[c] - u0[c], 1);

    // R5/R9: bulk read of 16 bytes, then one byte past the end
    bus_start();
    send_byte(8'hE9, -1, ak); chk("R5 bulk read address ack", int'(ak), 1);
    for (int c = 0; c < 8; c++) begin
      recv_byte(1'b0, h); chk("R5 bulk read first byte", int'(h), int'(expv[c][9:8]));
      recv_byte(1'b0, l); chk("R5 bulk read second byte", int'(l), int'(expv[c][7:0]));
    end
    recv_byte(1'b1, h); chk("R9 bulk read past end", int'(h), 0);
    bus_stop();
    chk("R5 sda released after NACK", int'(sda_pull), 0);

    // R4: half pair then STOP in bulk mode
    for (int c = 0; c < 8; c++) u0[c] = updc[c];
    bus_start();
    send_byte(8'hE8, -1, ak);
    send_byte(8'h01, -1, ak); send_byte(8'h11, -1, ak);
    send_byte(8'h03, -1, ak);
    bus_stop();
    expv[0] = 10'h111;
    chk_all("R4 half pair leaves channel B");
    chk("R4 no strobe for half pair", updc[1] - u0[1], 0);

    // R4: half pair then STOP in indexed mode
    bulk_mode = 1'b0;
    bus_start();
    send_byte(8'hE8, -1, ak); send_byte(8'h04, -1, ak); send_byte(8'h00, -1, ak);
    bus_stop();
    chk_all("R4 indexed half pair ignored");

    // R10: spike on a '1' data bit during SCL high
    filt_en = 1'b1;
    idx_write(7'h74, 8'h06, 8'h00, 8'hFF, 3, acks);
    expv[6] = 10'h0FF;
    chk_all("R10 spike filtered, write lands");
    filt_en = 1'b0;
    idx_write(7'h74, 8'h06, 8'h03, 8'hFF, 3, acks);
    chk_all("R10 unfiltered spike aborts write");
    chk("R12 sda released after spike", int'(sda_pull), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule